// File: doc/BRIEF.md
# Half-Bridge Interlock Dead-Time Generator

This block sits between a controller and the two gate drivers of a half-bridge. It accepts an on/off command for the upper switch and one for the lower switch. It returns two gate-enable outputs that are never both active while the interlock is in force. When one switch goes off, the opposite switch may turn on only after a dead time has passed. A three-bit code picks the dead time from eight fixed values. Each value is converted to clock cycles from the clock frequency parameter, rounding up.

A static bypass strap turns the two channels into independent followers. In that mode there is no lockout and no dead time. A block input from an external fault controller overrides everything and forces both gates off while it is high. Both command inputs are resynchronised to the block clock through two flops before any decision uses them.

Top module: `hb_deadtime_gen`

## Requirements
- R1: A command held HIGH turns its gate on. From an idle state with the dead time already satisfied, the gate rises on the third rising clock edge after the command changes (two synchroniser stages plus the output register).
- R2: A command going LOW drives its gate low on the third rising edge after the change. No dead time or other extra delay is added on turn-off.
- R3: With the bypass strap low, `gate_top` and `gate_bot` are never high together.
- R4: With the bypass strap low, a gate rises only after the opposite gate has been low for exactly N consecutive clock cycles. N is the dead-time cycle count of the current code, computed as ceil(t × CLK_HZ).
- R5: `dt_code` maps to dead time t as follows: 1 = 0.9 µs, 2 = 1.8 µs, 3 = 2.5 µs, 4 = 3.2 µs, 5 = 4.0 µs, 6 = 5.0 µs, 7 = 7.7 µs.
- R6: `dt_code` = 0 is the default and selects the longest dead time, 10 µs.
- R7: With the bypass strap low and both commands HIGH, a gate that is already on stays on and the other stays off. If neither gate was on, both stay off.
- R8: With `ilk_bypass` high, each gate follows its own command with the R1/R2 latency. Both may be on together, and no dead time applies.
- R9: While `fault_blk` is high, both gates are low from the next rising edge on, and no turn-on reaches either output. After `fault_blk` falls, a pending command whose dead time is met turns on at the next edge.
- R10: During reset both gates are low. After reset, the dead-time counters start at zero, so the first turn-on waits a full dead time counted from the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_top | input | 1 | Upper switch command, HIGH = on (asynchronous) |
| cmd_bot | input | 1 | Lower switch command, HIGH = on (asynchronous) |
| dt_code | input | 3 | Dead-time select code (R5, R6) |
| ilk_bypass | input | 1 | Strap: high runs the channels independently |
| fault_blk | input | 1 | Fault block, high forces both gates off |
| gate_top | output | 1 | Upper gate enable |
| gate_bot | output | 1 | Lower gate enable |

## Verification
The bench measures the both-low gap between a gate falling and the opposite gate rising for several codes, including the default. An off-by-one in the counter compare, or truncation instead of round-up, shows as a gap one cycle short or long. It checks the exact turn-off edge, because a design that routed turn-off through the dead-time path would hold a gate on too long. It drives both commands high from both the one-side-on and the idle states, where a naive design would glitch both gates on. It holds a command through a fault block and through reset exit, where a design that ignored the block or preloaded its counters would turn on early.

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen #(
  parameter int unsigned CLK_HZ = 200_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_top,
  input  logic       cmd_bot,
  input  logic [2:0] dt_code,
  input  logic       ilk_bypass,
  input  logic       fault_blk,
  output logic       gate_top,
  output logic       gate_bot
);

  function automatic longint unsigned dt_ns(input logic [2:0] c);
    case (c)
      3'd1:    return 64'd900;
      3'd2:    return 64'd1800;
      3'd3:    return 64'd2500;
      3'd4:    return 64'd3200;
      3'd5:    return 64'd4000;
      3'd6:    return 64'd5000;
      3'd7:    return 64'd7700;
      default: return 64'd10000;
    endcase
  endfunction

  function automatic int unsigned dt_cyc(input logic [2:0] c);
    longint unsigned prod;
    prod = dt_ns(c) * longint'(CLK_HZ);
    return 32'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  localparam int unsigned DT_MAX = dt_cyc(3'd0);
  localparam int          CW     = $clog2(DT_MAX + 1);

  logic [CW-1:0] need_tab [8];
  for (genvar g = 0; g < 8; g++) begin : g_tab
    assign need_tab[g] = CW'(dt_cyc(3'(g)) - 1);
  end

  logic [1:0]    sy_top, sy_bot;
  logic [CW-1:0] off_top, off_bot;
  logic [CW-1:0] need;
  logic          req_top, req_bot, nxt_top, nxt_bot;

  assign need    = need_tab[dt_code];
  assign req_top = sy_top[1] & ~fault_blk;
  assign req_bot = sy_bot[1] & ~fault_blk;

  always_comb begin
    if (ilk_bypass) begin
      nxt_top = req_top;
      nxt_bot = req_bot;
    end else begin
      nxt_top = req_top & ~gate_bot &
                (gate_top | ((off_bot >= need) & ~req_bot));
      nxt_bot = req_bot & ~gate_top &
                (gate_bot | ((off_top >= need) & ~req_top));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sy_top   <= '0;
      sy_bot   <= '0;
      off_top  <= '0;
      off_bot  <= '0;
      gate_top <= 1'b0;
      gate_bot <= 1'b0;
    end else begin
      sy_top   <= {sy_top[0], cmd_top};
      sy_bot   <= {sy_bot[0], cmd_bot};
      off_top  <= gate_top ? '0 : (&off_top ? off_top : off_top + 1'b1);
      off_bot  <= gate_bot ? '0 : (&off_bot ? off_bot : off_bot + 1'b1);
      gate_top <= nxt_top;
      gate_bot <= nxt_bot;
    end
  end

endmodule

// File: rtl/hb_deadtime_chk.sv
module hb_deadtime_chk #(
  parameter int unsigned CLK_HZ = 200_000_000
) (
  input logic       clk,
  input logic       rst,
  input logic       cmd_top,
  input logic       cmd_bot,
  input logic [2:0] dt_code,
  input logic       ilk_bypass,
  input logic       fault_blk,
  input logic       gate_top,
  input logic       gate_bot
);

  function automatic int unsigned want(input logic [2:0] c);
    longint unsigned ns;
    case (c)
      3'd1: ns = 900;   3'd2: ns = 1800; 3'd3: ns = 2500; 3'd4: ns = 3200;
      3'd5: ns = 4000;  3'd6: ns = 5000; 3'd7: ns = 7700; default: ns = 10000;
    endcase
    return 32'((ns * longint'(CLK_HZ) + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  int unsigned lo_top, lo_bot;
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_top <= 0;
      lo_bot <= 0;
    end else begin
      lo_top <= gate_top ? 0 : (lo_top < 32'd1_000_000 ? lo_top + 1 : lo_top);
      lo_bot <= gate_bot ? 0 : (lo_bot < 32'd1_000_000 ? lo_bot + 1 : lo_bot);
    end
  end

  p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    !ilk_bypass |-> !(gate_top && gate_bot));

  p_dead_bot_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_bot) && !$past(ilk_bypass)) |-> (lo_top >= want($past(dt_code))));

  p_dead_top_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(gate_top) && !$past(ilk_bypass)) |-> (lo_bot >= want($past(dt_code))));

  p_block_r9: assert property (@(posedge clk) disable iff (rst)
    fault_blk |=> (!gate_top && !gate_bot));

  p_turnoff_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_top, 3) |-> !gate_top);

endmodule

bind hb_deadtime_gen hb_deadtime_chk #(.CLK_HZ(CLK_HZ)) u_chk (
  .clk(clk), .rst(rst), .cmd_top(cmd_top), .cmd_bot(cmd_bot),
  .dt_code(dt_code), .ilk_bypass(ilk_bypass), .fault_blk(fault_blk),
  .gate_top(gate_top), .gate_bot(gate_bot)
);

// File: tb/tb_hb_deadtime_gen.sv
`timescale 1ns/1ps
module tb_hb_deadtime_gen;
  logic clk = 1'b0;
  logic rst, cmd_top, cmd_bot, ilk_bypass, fault_blk;
  logic [2:0] dt_code;
  logic gate_top, gate_bot;
  int n_chk = 0, n_bad = 0, excl_bad = 0;

  always #2.5 clk = ~clk;

  hb_deadtime_gen dut (
    .clk(clk), .rst(rst), .cmd_top(cmd_top), .cmd_bot(cmd_bot),
    .dt_code(dt_code), .ilk_bypass(ilk_bypass), .fault_blk(fault_blk),
    .gate_top(gate_top), .gate_bot(gate_bot)
  );

  always @(negedge clk)
    if (!rst && !ilk_bypass && gate_top && gate_bot) excl_bad++;

  function automatic int exp_cyc(input logic [2:0] c);
    int ns;
    case (c)
      3'd1: ns = 900;   3'd2: ns = 1800; 3'd3: ns = 2500; 3'd4: ns = 3200;
      3'd5: ns = 4000;  3'd6: ns = 5000; 3'd7: ns = 7700; default: ns = 10000;
    endcase
    return (ns + 4) / 5;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    step(3);
    chk(!gate_top && !gate_bot, "R10 gates low in reset", {gate_top, gate_bot}, 0);
    cmd_top = 1'b1;
    rst = 1'b0;
    step(exp_cyc(3'd1) - 1);
    chk(!gate_top, "R10 no turn-on before dead time after reset", gate_top, 0);
    step(1);
    chk(gate_top, "R10 turn-on once dead time after reset met", gate_top, 1);
  endtask

  task automatic t_latency;
    cmd_top = 1'b0;
    step(2100);
    cmd_top = 1'b1;
    step(2);
    chk(!gate_top, "R1 gate still low after two edges", gate_top, 0);
    step(1);
    chk(gate_top, "R1 gate high on third edge", gate_top, 1);
  endtask

  task automatic t_gap(input logic [2:0] code, input string req);
    int n = 0;
    dt_code = code;
    cmd_bot = 1'b0;
    cmd_top = 1'b1;
    step(2100);
    chk(gate_top, "R1 top on before gap test", gate_top, 1);
    cmd_top = 1'b0;
    cmd_bot = 1'b1;
    step(2);
    chk(gate_top, "R2 top still on after two edges", gate_top, 1);
    step(1);
    chk(!gate_top, "R2 top off on third edge", gate_top, 0);
    while (!gate_top && !gate_bot && n < 5000) begin
      n++;
      step(1);
    end
    chk(n == exp_cyc(code), req, n, exp_cyc(code));
    chk(gate_bot, "R4 bottom on after gap", gate_bot, 1);
  endtask

  task automatic t_tie;
    dt_code = 3'd1;
    cmd_bot = 1'b0;
    cmd_top = 1'b1;
    step(2100);
    cmd_bot = 1'b1;
    step(2100);
    chk(gate_top && !gate_bot, "R7 on side holds when both high", {gate_top, gate_bot}, 2);
    cmd_top = 1'b0;
    cmd_bot = 1'b0;
    step(2100);
    cmd_top = 1'b1;
    cmd_bot = 1'b1;
    step(2100);
    chk(!gate_top && !gate_bot, "R7 both stay off from idle", {gate_top, gate_bot}, 0);
    cmd_top = 1'b0;
    cmd_bot = 1'b0;
    step(10);
  endtask

  task automatic t_block;
    dt_code = 3'd1;
    cmd_top = 1'b1;
    step(2100);
    fault_blk = 1'b1;
    step(1);
    chk(!gate_top, "R9 block forces top off next edge", gate_top, 0);
    cmd_top = 1'b0;
    cmd_bot = 1'b1;
    step(400);
    chk(!gate_top && !gate_bot, "R9 no turn-on while blocked", {gate_top, gate_bot}, 0);
    fault_blk = 1'b0;
    step(1);
    chk(gate_bot, "R9 pending turn-on after release", gate_bot, 1);
    cmd_bot = 1'b0;
    step(10);
  endtask

  task automatic t_bypass;
    ilk_bypass = 1'b1;
    cmd_top = 1'b1;
    cmd_bot = 1'b1;
    step(2);
    chk(!gate_top && !gate_bot, "R8 latency in bypass", {gate_top, gate_bot}, 0);
    step(1);
    chk(gate_top && gate_bot, "R8 both on in bypass", {gate_top, gate_bot}, 3);
    cmd_top = 1'b0;
    step(3);
    chk(!gate_top && gate_bot, "R8 independent turn-off", {gate_top, gate_bot}, 1);
    cmd_top = 1'b1;
    step(3);
    chk(gate_top, "R8 no dead time in bypass", gate_top, 1);
    cmd_top = 1'b0;
    cmd_bot = 1'b0;
    step(4);
    ilk_bypass = 1'b0;
    step(4);
  endtask

  initial begin
    rst = 1'b1; cmd_top = 1'b0; cmd_bot = 1'b0;
    dt_code = 3'd1; ilk_bypass = 1'b0; fault_blk = 1'b0;
    t_reset();
    t_latency();
    t_gap(3'd0, "R6 default dead time 10us");
    t_gap(3'd1, "R5 R4 dead time code 1");
    t_gap(3'd4, "R5 R4 dead time code 4");
    t_gap(3'd6, "R5 dead time code 6");
    t_gap(3'd7, "R5 dead time code 7");
    t_tie();
    t_block();
    t_bypass();
    chk(excl_bad == 0, "R3 gates never both on with interlock", excl_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #750us;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule